// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block keeps a wall-clock calendar (seconds, minutes, hours, day of week, day of month, month and two-digit year) and advances it by one second each time a 1 Hz strobe arrives. The running time is held internally as plain binary counts. Each update copies the time into a bank of seven register bytes, which a register port outside this block reads. The bytes are encoded as packed BCD or as binary, and the hour byte is in 12-hour or 24-hour form, as two mode inputs select.

Each update runs in two phases, sequenced by a small state machine. In ST_IDLE the block waits for the strobe. The transition *start* (strobe present, oscillator-control field equal to the run code, no load or reload in the same cycle) advances the internal time and enters ST_HOLD, and the update-in-progress flag rises. ST_HOLD counts a fixed number of reference-clock ticks; the transition *window done* moves to ST_COPY. ST_COPY refreshes the register bytes, pulses update-ended and lowers the flag, then the transition *return* goes back to ST_IDLE. While the set-mode input is high, the flag is held low, the register bytes are not refreshed and no update-ended pulse is given. A parallel load writes all seven bytes at once. With set-mode low, a load also sets the internal time. With set-mode high, it writes only the bytes, and the internal time is reloaded from the bytes when set-mode falls. The century used for the leap-year rule is fixed by a parameter (default 20, that is years 2000 to 2099).

Top module: `calendar_tod`

## Requirements
- R1: On each accepted update, seconds advance by one. Seconds at or above 60 wrap to 0 and carry into minutes; minutes wrap the same way into hours; hours at or above 24 wrap to 0 and carry into the day.
- R2: Day of week counts 0 to 6, advances only on a day carry, and goes from 6 to 0.
- R3: Month lengths are 31 for months 1,3,5,7,8,10,12 and 30 for 4,6,9,11. When the day passes the month length, the day becomes 1 and the month advances. After month 12 comes month 1, and the year advances, with 99 followed by 00.
- R4: February has 29 days when the two-digit year is a multiple of 4, except for year 00 in a century not divisible by 4. With the default century 20, year 00 is a leap year.
- R5: binary_mode=0 gives packed BCD bytes (tens in bits 7:4, units in bits 3:0). binary_mode=1 gives plain binary. Loaded bytes are decoded with the same rule.
- R6: hour24_mode=0 gives a 12-hour byte: hour mod 12 in bits 6:0, with bit 7 set for hours 12 to 23 (so noon reads as PM 0). On load in this mode, a set bit 7 adds 12 to the hour. hour24_mode=1 gives 0 to 23.
- R7: A strobe is accepted only when osc_sel equals 3'b010. Any other value ignores it: no flag, no pulse, and the time does not advance.
- R8: The flag uip rises in the cycle after an accepted strobe and stays high for UIP_TICKS+1 cycles while ref_tick is held high. In the cycle it falls, time_q shows the new time and update_done is high for exactly one cycle.
- R9: While set_mode is high, uip is forced low, time_q is not refreshed and no update_done pulse occurs, including for an update already in its window.
- R10: A load_en cycle makes time_q equal load_data on the next cycle. The byte order is seconds in bits 7:0, minutes 15:8, hours 23:16, day of week 31:24, day of month 39:32, month 47:40 and year 55:48. With set_mode low, the load also sets the internal time. With set_mode high, the internal time is reloaded from time_q when set_mode falls.
- R11: When load_en and sec_tick are high in the same cycle, the load takes effect and the strobe is dropped.
- R12: Out-of-range loaded digits are kept as given and wrap at the next rollover check. For example, BCD seconds 7A (decoded as 80) become 00 on the next update, with a minute carry.
- R13: After reset, time_q reads year 00, month 01, day 01, weekday 0, 00:00:00, and uip and update_done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle 1 Hz update strobe |
| ref_tick | input | 1 | Reference-clock enable that times the update window |
| binary_mode | input | 1 | 1: binary bytes, 0: packed BCD bytes |
| hour24_mode | input | 1 | 1: 24-hour byte, 0: 12-hour byte with PM in bit 7 |
| osc_sel | input | 3 | Oscillator control field; 3'b010 lets the clock run |
| set_mode | input | 1 | Freezes the register bytes and suppresses update flags |
| load_en | input | 1 | Loads all seven bytes from load_data |
| load_data | input | 56 | Seven time/date bytes to load |
| time_q | output | 56 | Seven register bytes of the current time |
| uip | output | 1 | Update-in-progress flag |
| update_done | output | 1 | One-cycle update-ended pulse |

## Verification
A wrong internal counter is hidden until the next ST_COPY, so it shows in time_q about UIP_TICKS+2 cycles after a strobe. A fault in a carry path shows only when a vector sits right on that boundary, so each vector loads a time one second before a seconds, hour, day, month, leap or year boundary and checks the bytes after a single update. A fault in the sequencer shows at once on uip and update_done, so their timing is checked cycle by cycle, along with the cases where the flag must stay low (bad oscillator code, set mode, load collision).

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;
    localparam int unsigned FW       = 8;
    localparam int unsigned N_FIELDS = 7;
    localparam int unsigned F_HOUR   = 2;

    // seconds sit in the least significant byte; layout equals the byte bus
    typedef struct packed {
        logic [FW-1:0] year;
        logic [FW-1:0] mon;
        logic [FW-1:0] mday;
        logic [FW-1:0] wday;
        logic [FW-1:0] hour;
        logic [FW-1:0] min;
        logic [FW-1:0] sec;
    } cal_time_t;

    typedef logic [N_FIELDS-1:0][FW-1:0] cal_bytes_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_COPY = 2'd2
    } upd_state_t;

    localparam logic [2:0] OSC_RUN = 3'b010;

    localparam cal_time_t RESET_TIME = '{
        year: 8'd0, mon: 8'd1, mday: 8'd1, wday: 8'd0,
        hour: 8'd0, min: 8'd0, sec: 8'd0
    };

    function automatic logic [FW-1:0] to_bcd(input logic [FW-1:0] v);
        return {4'(v / 8'd10), 4'(v % 8'd10)};
    endfunction

    function automatic logic [FW-1:0] from_bcd(input logic [FW-1:0] b);
        return (8'(b[7:4]) * 8'd10) + 8'(b[3:0]);
    endfunction
endpackage

// File: rtl/cal_step.sv
`timescale 1ns/1ps
module cal_step
    import cal_pkg::*;
#(
    parameter int unsigned CENTURY = 20
) (
    input  cal_time_t cur,
    output cal_time_t nxt
);
    localparam bit CENT_LEAP = ((CENTURY % 4) == 0);

    logic          cent_year;
    logic          leap;
    logic [FW-1:0] dim;

    always_comb begin
        cent_year = ((cur.year % 8'd100) == 8'd0);
        leap      = (cur.year[1:0] == 2'b00) && (!cent_year || CENT_LEAP);
        case (cur.mon)
            8'd2:                  dim = leap ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11: dim = 8'd30;
            default:               dim = 8'd31;
        endcase
    end

    always_comb begin
        nxt     = cur;
        nxt.sec = cur.sec + 8'd1;
        if (nxt.sec >= 8'd60) begin
            nxt.sec = 8'd0;
            nxt.min = cur.min + 8'd1;
            if (nxt.min >= 8'd60) begin
                nxt.min  = 8'd0;
                nxt.hour = cur.hour + 8'd1;
                if (nxt.hour >= 8'd24) begin
                    nxt.hour = 8'd0;
                    nxt.wday = (cur.wday >= 8'd6) ? 8'd0 : cur.wday + 8'd1;
                    nxt.mday = cur.mday + 8'd1;
                    if (nxt.mday > dim) begin
                        nxt.mday = 8'd1;
                        nxt.mon  = cur.mon + 8'd1;
                        if (nxt.mon > 8'd12) begin
                            nxt.mon  = 8'd1;
                            nxt.year = (cur.year >= 8'd99) ? 8'd0 : cur.year + 8'd1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/cal_encode.sv
`timescale 1ns/1ps
module cal_encode
    import cal_pkg::*;
(
    input  cal_bytes_t bin_in,
    input  logic       binary_mode,
    input  logic       hour24_mode,
    output cal_bytes_t reg_out
);
    for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
        if (i == F_HOUR) begin : g_hour
            logic [FW-1:0] h12;
            logic          pm;
            logic [FW-1:0] e24;
            logic [FW-1:0] e12;
            assign h12 = bin_in[i] % 8'd12;
            assign pm  = (bin_in[i] >= 8'd12);
            assign e24 = binary_mode ? bin_in[i] : to_bcd(bin_in[i]);
            assign e12 = (binary_mode ? h12 : to_bcd(h12)) | {pm, 7'b0};
            assign reg_out[i] = hour24_mode ? e24 : e12;
        end else begin : g_plain
            assign reg_out[i] = binary_mode ? bin_in[i] : to_bcd(bin_in[i]);
        end
    end
endmodule

// File: rtl/cal_decode.sv
`timescale 1ns/1ps
module cal_decode
    import cal_pkg::*;
(
    input  cal_bytes_t reg_in,
    input  logic       binary_mode,
    input  logic       hour24_mode,
    output cal_bytes_t bin_out
);
    for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
        if (i == F_HOUR) begin : g_hour
            logic [FW-1:0] low7;
            logic [FW-1:0] base;
            assign low7 = {1'b0, reg_in[i][6:0]};
            assign base = binary_mode ? low7 : from_bcd(low7);
            assign bin_out[i] = (!hour24_mode && reg_in[i][7]) ? base + 8'd12 : base;
        end else begin : g_plain
            assign bin_out[i] = binary_mode ? reg_in[i] : from_bcd(reg_in[i]);
        end
    end
endmodule

// File: rtl/cal_update_ctl.sv
`timescale 1ns/1ps
module cal_update_ctl
    import cal_pkg::*;
#(
    parameter int unsigned UIP_TICKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       ref_tick,
    input  logic [2:0] osc_sel,
    input  logic       set_mode,
    input  logic       hold_off,
    output logic       adv_en,
    output logic       copy_en,
    output logic       uip,
    output logic       update_done
);
    localparam int unsigned CW = (UIP_TICKS > 1) ? $clog2(UIP_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(UIP_TICKS - 1);

    upd_state_t    st, st_nx;
    logic [CW-1:0] cnt;
    logic          start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        start = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (sec_tick && !hold_off && osc_sel == OSC_RUN) begin
                    start = 1'b1;
                    st_nx = ST_HOLD;
                end
            end
            ST_HOLD: if (ref_tick && cnt == LAST) st_nx = ST_COPY;
            ST_COPY: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (st != ST_HOLD)  cnt <= '0;
        else if (ref_tick)       cnt <= cnt + 1'b1;
    end

    assign adv_en  = start;
    assign copy_en = (st == ST_COPY) && !set_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uip         <= 1'b0;
            update_done <= 1'b0;
        end else begin
            update_done <= (st == ST_COPY) && uip && !set_mode;
            if (set_mode)            uip <= 1'b0;
            else if (start)          uip <= 1'b1;
            else if (st == ST_COPY)  uip <= 1'b0;
        end
    end

    p_uip_low_in_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_mode |=> !uip);
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        update_done |=> !update_done);
    p_done_follows_uip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        update_done |-> $past(uip));
    p_bad_osc_no_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && osc_sel != OSC_RUN) |=> !uip);
    p_load_drops_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && hold_off) |=> !uip);
endmodule

// File: rtl/calendar_tod.sv
`timescale 1ns/1ps
module calendar_tod
    import cal_pkg::*;
#(
    parameter int unsigned UIP_TICKS = 8,
    parameter int unsigned CENTURY   = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sec_tick,
    input  logic        ref_tick,
    input  logic        binary_mode,
    input  logic        hour24_mode,
    input  logic [2:0]  osc_sel,
    input  logic        set_mode,
    input  logic        load_en,
    input  logic [55:0] load_data,
    output logic [55:0] time_q,
    output logic        uip,
    output logic        update_done
);
    cal_time_t  cur_q;
    cal_time_t  nxt_t;
    cal_bytes_t regs_q;
    cal_bytes_t enc_b;
    cal_bytes_t dec_src;
    cal_bytes_t dec_b;
    logic       set_q;
    logic       set_fall;
    logic       hold_off;
    logic       adv_en;
    logic       copy_en;

    assign set_fall = set_q && !set_mode;
    assign hold_off = load_en || set_fall;
    assign dec_src  = load_en ? cal_bytes_t'(load_data) : regs_q;

    cal_step #(.CENTURY(CENTURY)) u_step (
        .cur (cur_q),
        .nxt (nxt_t)
    );

    cal_encode u_enc (
        .bin_in      (cal_bytes_t'(cur_q)),
        .binary_mode (binary_mode),
        .hour24_mode (hour24_mode),
        .reg_out     (enc_b)
    );

    cal_decode u_dec (
        .reg_in      (dec_src),
        .binary_mode (binary_mode),
        .hour24_mode (hour24_mode),
        .bin_out     (dec_b)
    );

    cal_update_ctl #(.UIP_TICKS(UIP_TICKS)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sec_tick    (sec_tick),
        .ref_tick    (ref_tick),
        .osc_sel     (osc_sel),
        .set_mode    (set_mode),
        .hold_off    (hold_off),
        .adv_en      (adv_en),
        .copy_en     (copy_en),
        .uip         (uip),
        .update_done (update_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) set_q <= 1'b0;
        else        set_q <= set_mode;
    end

    // internal binary time: load beats reload beats advance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cur_q <= RESET_TIME;
        else if (load_en && !set_mode)  cur_q <= cal_time_t'(dec_b);
        else if (set_fall && !load_en)  cur_q <= cal_time_t'(dec_b);
        else if (adv_en)                cur_q <= nxt_t;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        regs_q <= cal_bytes_t'(RESET_TIME);
        else if (load_en)  regs_q <= cal_bytes_t'(load_data);
        else if (copy_en)  regs_q <= enc_b;
    end

    assign time_q = regs_q;

    p_load_visible_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> time_q == $past(load_data));
    p_set_freezes_bytes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mode && !load_en) |=> $stable(time_q));
    p_sec_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && cur_q.sec < 8'd59) |=> cur_q.sec == $past(cur_q.sec) + 8'd1);
    p_wday_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && cur_q.wday < 8'd7) |=> cur_q.wday < 8'd7);
endmodule

// File: tb/calendar_tod_test.sv
`timescale 1ns/1ps
module calendar_tod_test;
    localparam int unsigned UIP_TICKS = 8;
    localparam int unsigned NVEC      = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        ref_tick = 1'b1;
    logic        binary_mode = 1'b0;
    logic        hour24_mode = 1'b1;
    logic [2:0]  osc_sel = 3'b010;
    logic        set_mode = 1'b0;
    logic        load_en = 1'b0;
    logic [55:0] load_data = '0;
    logic [55:0] time_q;
    logic        uip;
    logic        update_done;

    int checks = 0;
    int fails  = 0;
    int uip_seen = 0;
    int done_seen = 0;

    always #5 clk = ~clk;

    calendar_tod #(.UIP_TICKS(UIP_TICKS)) uut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .ref_tick(ref_tick),
        .binary_mode(binary_mode), .hour24_mode(hour24_mode), .osc_sel(osc_sel),
        .set_mode(set_mode), .load_en(load_en), .load_data(load_data),
        .time_q(time_q), .uip(uip), .update_done(update_done)
    );

    always @(negedge clk) begin
        if (uip) uip_seen++;
        if (update_done) done_seen++;
    end

    // {binary, hour24, load bytes, expected bytes after one update}
    // bytes: {year, month, mday, wday, hour, min, sec}
    localparam logic [113:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 56'h99123106235959, 56'h00010100000000}, // R1 R2 R3 year wrap
        {1'b0, 1'b1, 56'h23022802235959, 56'h23030103000000}, // R4 common Feb
        {1'b0, 1'b1, 56'h24022803235959, 56'h24022904000000}, // R4 leap Feb
        {1'b0, 1'b1, 56'h00022801235959, 56'h00022902000000}, // R4 century year
        {1'b1, 1'b1, 56'h2D060F050C223B, 56'h2D060F050C2300}, // R5 binary
        {1'b0, 1'b0, 56'h10043000915959, 56'h10050101000000}, // R6 PM 11 -> midnight
        {1'b0, 1'b0, 56'h30070504115959, 56'h30070504800000}, // R6 AM 11 -> noon
        {1'b1, 1'b0, 56'h05030A02813B3B, 56'h05030A02820000}, // R5 R6 binary 12h
        {1'b0, 1'b1, 56'h2106150308107A, 56'h21061503081100}, // R12 bad digits
        {1'b0, 1'b1, 56'h21063006235959, 56'h21070100000000}, // R3 30-day month
        {1'b0, 1'b1, 56'h24022904235959, 56'h24030105000000}, // R4 leap day end
        {1'b0, 1'b0, 56'h01010101805959, 56'h01010101810000}  // R6 12 PM -> 1 PM
    };

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R1/R2/R3";
            1, 2, 3, 10: return "R4";
            4: return "R5";
            5, 6, 11: return "R6";
            7: return "R6(binary)";
            8: return "R12";
            default: return "R3";
        endcase
    endfunction

    task automatic check(input string tag, input logic [55:0] act, input logic [55:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_load(input logic [55:0] d);
        load_data = d;
        load_en   = 1'b1;
        @(negedge clk);
        load_en   = 1'b0;
    endtask

    task automatic do_tick();
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        cycles(3);
        // R13 reset state
        check("R13 time_q", time_q, 56'h00010100000000);
        check("R13 uip", 56'(uip), 56'd0);
        check("R13 update_done", 56'(update_done), 56'd0);
        rst_n = 1'b1;
        cycles(2);

        // table walk: load, one update, compare
        for (int i = 0; i < NVEC; i++) begin
            binary_mode = VEC[i][113];
            hour24_mode = VEC[i][112];
            @(negedge clk);
            do_load(VEC[i][111:56]);
            check("R10 load shown", time_q, VEC[i][111:56]);
            done_seen = 0;
            do_tick();
            cycles(12);
            check(vec_tag(i), time_q, VEC[i][55:0]);
            check("R8 one done pulse", 56'(done_seen), 56'd1);
        end

        // R8 window timing, BCD 24h, 12:00:00
        binary_mode = 1'b0;
        hour24_mode = 1'b1;
        @(negedge clk);
        do_load(56'h00010100120000);
        do_tick();
        check("R8 uip rises", 56'(uip), 56'd1);
        check("R8 bytes held during window", time_q, 56'h00010100120000);
        begin
            int n = 0;
            while (uip && n < 50) begin
                n++;
                @(negedge clk);
            end
            check("R8 window length", 56'(n), 56'(UIP_TICKS + 1));
        end
        check("R8 done at uip fall", 56'(update_done), 56'd1);
        check("R8 new time at uip fall", time_q, 56'h00010100120001);
        @(negedge clk);
        check("R8 done one cycle", 56'(update_done), 56'd0);

        // R7 oscillator code other than 010 drops the strobe
        osc_sel = 3'b110;
        uip_seen = 0;
        done_seen = 0;
        do_tick();
        cycles(12);
        check("R7 no uip", 56'(uip_seen), 56'd0);
        check("R7 no done", 56'(done_seen), 56'd0);
        check("R7 time unchanged", time_q, 56'h00010100120001);
        osc_sel = 3'b010;
        @(negedge clk);
        do_tick();
        cycles(12);
        check("R7 no skipped second counted", time_q, 56'h00010100120002);

        // R11 load and strobe together
        uip_seen = 0;
        load_data = 56'h00010100070809;
        load_en = 1'b1;
        sec_tick = 1'b1;
        @(negedge clk);
        load_en = 1'b0;
        sec_tick = 1'b0;
        cycles(12);
        check("R11 load kept", time_q, 56'h00010100070809);
        check("R11 strobe dropped", 56'(uip_seen), 56'd0);
        do_tick();
        cycles(12);
        check("R11 internal took load", time_q, 56'h00010100070810);

        // R9 R10 set mode: load writes bytes only, updates hidden
        set_mode = 1'b1;
        @(negedge clk);
        do_load(56'h00010100050607);
        check("R10 load in set mode", time_q, 56'h00010100050607);
        uip_seen = 0;
        done_seen = 0;
        do_tick();
        cycles(12);
        check("R9 no uip in set", 56'(uip_seen), 56'd0);
        check("R9 no done in set", 56'(done_seen), 56'd0);
        check("R9 bytes frozen", time_q, 56'h00010100050607);
        set_mode = 1'b0;
        cycles(2);
        do_tick();
        cycles(12);
        check("R10 reload on set fall", time_q, 56'h00010100050608);

        // R9 set raised inside the window
        done_seen = 0;
        do_tick();
        cycles(3);
        check("R9 window open", 56'(uip), 56'd1);
        set_mode = 1'b1;
        @(negedge clk);
        check("R9 uip dropped by set", 56'(uip), 56'd0);
        cycles(12);
        check("R9 no done after set", 56'(done_seen), 56'd0);
        check("R9 bytes unchanged", time_q, 56'h00010100050608);
        set_mode = 1'b0;
        cycles(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule